// File: doc/BRIEF.md
# Framebuffer Display Scanout Controller

This block refreshes a fixed-size true-colour display from a framebuffer held in ordinary memory. It counts out raster timing (pixel, porch and sync periods for each line and each frame) on a pixel clock enable. For every visible pixel it computes a word address, raises a single-word read request on a pixel memory port, and presents the returned colour on 8-bit red, green and blue outputs. These outputs come with a data-enable and active-low sync pulses, all delayed by the same amount.

Software sees two 32-bit registers, selected by a one-bit word index. Index 0 holds the framebuffer base. Only its upper bits take part in fetching, so a buffer must sit on a coarse boundary (2 MiB by default). Index 1 holds the control word: bit 0 turns scanout on and bit 1 walks the buffer backwards, which shows the picture turned by 180 degrees. Each stored row takes a fixed pitch of 1024 words, and only the first 640 of them are ever read. The three settings are copied into a shadow set once per frame, at the first tick of vertical blanking. A frame is therefore never split between two configurations.

Top module: `fb_scanout`

## Requirements
- R1: A write to index 0 reads back as the full 32-bit value. A write to index 1 reads back with bits 1:0 as written and all other bits zero. After reset both read as zero.
- R2: Only the top BASE_BITS (11) bits of the base register affect fetch addresses. The lower bits are dropped.
- R3: A line is H_VIS+H_FP+H_SYNC+H_BP ticks long (640+16+96+48). hsync_n is low for H_SYNC ticks, starting H_VIS+H_FP ticks into the line.
- R4: A frame is V_VIS+V_FP+V_SYNC+V_BP lines long (480+10+2+33). vsync_n is low for V_SYNC whole lines, starting at line V_VIS+V_FP.
- R5: With rotation off and scanout on, one request is made per visible pixel in raster order. The request for column x of row y is at byte address base + y*PITCH_WORDS*4 + x*4. No request is made in blanking or for words past column H_VIS-1.
- R6: With rotation on, the request for screen position (x, y) is at base + (V_VIS-1-y)*PITCH_WORDS*4 + (H_VIS-1-x)*4.
- R7: de, hsync_n and vsync_n for a position appear RD_LAT+1 ticks after the tick at which that position's request is made. Memory data is expected RD_LAT ticks after its request.
- R8: While de is high, red, green and blue carry bits 23:16, 15:8 and 7:0 of the returned word, and bits 31:24 are ignored. While de is low all three are zero.
- R9: While the shadow enable is 0 (including from reset until the first vertical blanking), no request is made, de stays low and the colour outputs are zero. The sync pulses keep running.
- R10: Enable, rotate and base are copied into the shadow set only at the first tick of line V_VIS. Writes made at any other time do not change the frame in progress.
- R11: A clock cycle with pix_ce low changes no counter, pipeline stage or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pix_ce | input | 1 | Pixel tick enable |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register word index for write and read (0 base, 1 control) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the register chosen by reg_sel |
| mem_req | output | 1 | Pixel word read request, taken on ticks |
| mem_addr | output | 32 | Byte address of the requested word |
| mem_rdata | input | 32 | Returned pixel word, valid RD_LAT ticks after the request |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| de | output | 1 | Visible pixel data enable |
| red | output | 8 | Red level |
| green | output | 8 | Green level |
| blue | output | 8 | Blue level |

## Verification
The assertions assume that the memory port holds data for exactly RD_LAT ticks and that pix_ce may drop in any cycle. The stimulus meets this with a bench memory that advances its two-stage read pipe only on ticks, and with one phase in which pix_ce is drawn at random each cycle. Register writes are kept off the one tick where the shadow copy is taken, so the expected shadow is never ambiguous. Between them, directed writes and random writes cover mid-frame changes, odd low base bits, rotation and disable.

// File: rtl/fb_scanout_pkg.sv
`timescale 1ns/1ps
package fb_scanout_pkg;
  localparam int unsigned WORD_W = 32;

  typedef struct packed {
    logic              enable;
    logic              rotate;
    logic [WORD_W-1:0] base;
  } scan_cfg_t;

  typedef struct packed {
    logic de;
    logic hs_n;
    logic vs_n;
  } vid_ctl_t;
endpackage

// File: rtl/fb_regs.sv
`timescale 1ns/1ps
module fb_regs
  import fb_scanout_pkg::*;
#(
  parameter int unsigned BASE_BITS = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              sel,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data,
  input  logic              load,
  output scan_cfg_t         cfg
);
  localparam logic [WORD_W-1:0] KEEP_MASK =
    {{BASE_BITS{1'b1}}, {(WORD_W-BASE_BITS){1'b0}}};

  logic [WORD_W-1:0] base_q, base_d;
  logic              en_q, en_d, rot_q, rot_d;
  scan_cfg_t         cfg_q, cfg_d;
  logic              unused_ctl_bits;

  assign unused_ctl_bits = ^wr_data[WORD_W-1:2];

  always_comb begin
    base_d = base_q;
    en_d   = en_q;
    rot_d  = rot_q;
    if (wr_en) begin
      if (sel) begin
        en_d  = wr_data[0];
        rot_d = wr_data[1];
      end else begin
        base_d = wr_data;
      end
    end
    cfg_d = cfg_q;
    if (load) begin
      cfg_d.enable = en_q;
      cfg_d.rotate = rot_q;
      cfg_d.base   = base_q & KEEP_MASK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      en_q   <= 1'b0;
      rot_q  <= 1'b0;
      cfg_q  <= '0;
    end else begin
      base_q <= base_d;
      en_q   <= en_d;
      rot_q  <= rot_d;
      cfg_q  <= cfg_d;
    end
  end

  assign rd_data = sel ? {{(WORD_W-2){1'b0}}, rot_q, en_q} : base_q;
  assign cfg     = cfg_q;

  // R10: the shadow set only moves on the frame load tick
  p_shadow_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(cfg_q));

  // R1: a base write is held for readback
  p_base_kept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !sel) |=> (base_q == $past(wr_data)));
endmodule

// File: rtl/fb_timing.sv
`timescale 1ns/1ps
module fb_timing #(
  parameter int unsigned H_VIS  = 640,
  parameter int unsigned H_FP   = 16,
  parameter int unsigned H_SYNC = 96,
  parameter int unsigned H_BP   = 48,
  parameter int unsigned V_VIS  = 480,
  parameter int unsigned V_FP   = 10,
  parameter int unsigned V_SYNC = 2,
  parameter int unsigned V_BP   = 33,
  parameter int unsigned HW     = 10,
  parameter int unsigned VW     = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce,
  output logic [HW-1:0] hcnt,
  output logic [VW-1:0] vcnt,
  output logic          active,
  output logic          hs_n,
  output logic          vs_n,
  output logic          frame_load
);
  localparam int unsigned H_TOT = H_VIS + H_FP + H_SYNC + H_BP;
  localparam int unsigned V_TOT = V_VIS + V_FP + V_SYNC + V_BP;
  localparam int unsigned HS_B  = H_VIS + H_FP;
  localparam int unsigned HS_E  = HS_B + H_SYNC;
  localparam int unsigned VS_B  = V_VIS + V_FP;
  localparam int unsigned VS_E  = VS_B + V_SYNC;

  logic [HW-1:0] h_q, h_d;
  logic [VW-1:0] v_q, v_d;

  always_comb begin
    h_d = h_q;
    v_d = v_q;
    if (ce) begin
      if (h_q == HW'(H_TOT-1)) begin
        h_d = '0;
        v_d = (v_q == VW'(V_TOT-1)) ? '0 : v_q + VW'(1);
      end else begin
        h_d = h_q + HW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_q <= '0;
      v_q <= '0;
    end else begin
      h_q <= h_d;
      v_q <= v_d;
    end
  end

  assign hcnt       = h_q;
  assign vcnt       = v_q;
  assign active     = (h_q < HW'(H_VIS)) && (v_q < VW'(V_VIS));
  assign hs_n       = !((h_q >= HW'(HS_B)) && (h_q < HW'(HS_E)));
  assign vs_n       = !((v_q >= VW'(VS_B)) && (v_q < VW'(VS_E)));
  assign frame_load = ce && (h_q == '0) && (v_q == VW'(V_VIS));

  // R11: counters freeze without a tick
  p_hold_no_ce_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> ($stable(h_q) && $stable(v_q)));

  // R3: column counter stays inside the line
  p_hrange_r3: assert property (@(posedge clk) disable iff (!rst_n)
    h_q <= HW'(H_TOT-1));

  // R4: vertical sync only inside blanking
  p_vsync_blank_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !vs_n |-> !active);
endmodule

// File: rtl/fb_fetch.sv
`timescale 1ns/1ps
module fb_fetch
  import fb_scanout_pkg::*;
#(
  parameter int unsigned H_VIS       = 640,
  parameter int unsigned V_VIS       = 480,
  parameter int unsigned PITCH_WORDS = 1024,
  parameter int unsigned HW          = 10,
  parameter int unsigned VW          = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HW-1:0]     hcnt,
  input  logic [VW-1:0]     vcnt,
  input  logic              active,
  input  scan_cfg_t         cfg,
  output logic              mem_req,
  output logic [WORD_W-1:0] mem_addr
);
  localparam logic [WORD_W-1:0] PITCH_BYTES = WORD_W'(PITCH_WORDS * 4);

  logic [WORD_W-1:0] col, row, offs;

  always_comb begin
    if (cfg.rotate) begin
      col = WORD_W'(H_VIS-1) - WORD_W'(hcnt);
      row = WORD_W'(V_VIS-1) - WORD_W'(vcnt);
    end else begin
      col = WORD_W'(hcnt);
      row = WORD_W'(vcnt);
    end
    offs = (row * PITCH_BYTES) + (col << 2);
  end

  assign mem_req  = active && cfg.enable;
  assign mem_addr = cfg.base + offs;

  // R5: requests only for visible positions
  p_req_area_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> active);

  // R5: word aligned fetches
  p_req_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00));

  // R6: mirrored column stays within the shown part of a row
  p_col_in_row_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (col < WORD_W'(H_VIS)));
endmodule

// File: rtl/fb_pixel_out.sv
`timescale 1ns/1ps
module fb_pixel_out
  import fb_scanout_pkg::*;
#(
  parameter int unsigned RD_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  vid_ctl_t          ctl_in,
  input  logic [WORD_W-1:0] rd_data,
  output vid_ctl_t          ctl_out,
  output logic [7:0]        red,
  output logic [7:0]        green,
  output logic [7:0]        blue
);
  localparam vid_ctl_t IDLE = '{de: 1'b0, hs_n: 1'b1, vs_n: 1'b1};

  vid_ctl_t [RD_LAT-1:0] pipe_q, pipe_d;
  vid_ctl_t              tail, out_q, out_d;
  logic [23:0]           rgb_q, rgb_d;
  logic                  unused_pad;

  assign unused_pad = ^rd_data[WORD_W-1:24];
  assign tail       = pipe_q[RD_LAT-1];

  always_comb begin
    pipe_d    = pipe_q;
    out_d     = out_q;
    rgb_d     = rgb_q;
    if (ce) begin
      pipe_d[0] = ctl_in;
      for (int i = 1; i < RD_LAT; i++) pipe_d[i] = pipe_q[i-1];
      out_d = tail;
      rgb_d = tail.de ? rd_data[23:0] : 24'h0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= {RD_LAT{IDLE}};
      out_q  <= IDLE;
      rgb_q  <= '0;
    end else begin
      pipe_q <= pipe_d;
      out_q  <= out_d;
      rgb_q  <= rgb_d;
    end
  end

  assign ctl_out = out_q;
  assign red     = rgb_q[23:16];
  assign green   = rgb_q[15:8];
  assign blue    = rgb_q[7:0];

  // R8: black whenever data enable is low
  p_black_blank_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_q.de |-> (rgb_q == 24'h0));

  // R11: colour holds without a tick
  p_rgb_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> ($stable(rgb_q) && $stable(out_q)));
endmodule

// File: rtl/fb_scanout.sv
`timescale 1ns/1ps
module fb_scanout
  import fb_scanout_pkg::*;
#(
  parameter int unsigned H_VIS       = 640,
  parameter int unsigned H_FP        = 16,
  parameter int unsigned H_SYNC      = 96,
  parameter int unsigned H_BP        = 48,
  parameter int unsigned V_VIS       = 480,
  parameter int unsigned V_FP        = 10,
  parameter int unsigned V_SYNC      = 2,
  parameter int unsigned V_BP        = 33,
  parameter int unsigned PITCH_WORDS = 1024,
  parameter int unsigned BASE_BITS   = 11,
  parameter int unsigned RD_LAT      = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pix_ce,
  input  logic        reg_we,
  input  logic        reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic [31:0] mem_rdata,
  output logic        hsync_n,
  output logic        vsync_n,
  output logic        de,
  output logic [7:0]  red,
  output logic [7:0]  green,
  output logic [7:0]  blue
);
  localparam int unsigned HW = $clog2(H_VIS + H_FP + H_SYNC + H_BP);
  localparam int unsigned VW = $clog2(V_VIS + V_FP + V_SYNC + V_BP);

  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;
  logic          active, hs_n_raw, vs_n_raw, frame_load;
  scan_cfg_t     cfg;
  vid_ctl_t      ctl_raw, ctl_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  fb_regs #(.BASE_BITS(BASE_BITS)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .wr_en(reg_we), .sel(reg_sel),
    .wr_data(reg_wdata), .rd_data(reg_rdata), .load(frame_load), .cfg(cfg)
  );

  fb_timing #(
    .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
    .HW(HW), .VW(VW)
  ) u_timing (
    .clk(clk), .rst_n(rst_int_n), .ce(pix_ce), .hcnt(hcnt), .vcnt(vcnt),
    .active(active), .hs_n(hs_n_raw), .vs_n(vs_n_raw), .frame_load(frame_load)
  );

  fb_fetch #(
    .H_VIS(H_VIS), .V_VIS(V_VIS), .PITCH_WORDS(PITCH_WORDS), .HW(HW), .VW(VW)
  ) u_fetch (
    .clk(clk), .rst_n(rst_int_n), .hcnt(hcnt), .vcnt(vcnt), .active(active),
    .cfg(cfg), .mem_req(mem_req), .mem_addr(mem_addr)
  );

  assign ctl_raw = '{de: mem_req, hs_n: hs_n_raw, vs_n: vs_n_raw};

  fb_pixel_out #(.RD_LAT(RD_LAT)) u_pix (
    .clk(clk), .rst_n(rst_int_n), .ce(pix_ce), .ctl_in(ctl_raw),
    .rd_data(mem_rdata), .ctl_out(ctl_out), .red(red), .green(green), .blue(blue)
  );

  assign hsync_n = ctl_out.hs_n;
  assign vsync_n = ctl_out.vs_n;
  assign de      = ctl_out.de;

  // R9: a disabled shadow set never fetches
  p_dark_when_off_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    !cfg.enable |-> !mem_req);
endmodule

// File: tb/fb_scanout_tb.sv
`timescale 1ns/1ps
module fb_scanout_tb;
  localparam int unsigned HV = 8, HF = 2, HSY = 3, HB = 2;
  localparam int unsigned VV = 4, VF = 1, VSY = 2, VB = 1;
  localparam int unsigned PW = 16, BB = 11, LAT = 2;
  localparam int unsigned HT = HV + HF + HSY + HB;
  localparam int unsigned VT = VV + VF + VSY + VB;
  localparam int unsigned FT = HT * VT;
  localparam int unsigned LOAD = VV * HT;
  localparam int unsigned HSB = HV + HF, HSE = HSB + HSY;
  localparam int unsigned VSB = VV + VF, VSE = VSB + VSY;
  localparam logic [31:0] MASK = ~((32'd1 << (32 - BB)) - 32'd1);

  typedef struct packed {
    logic de; logic hs; logic vs; logic [23:0] rgb;
  } exp_t;

  logic clk, rst_n, pix_ce, reg_we, reg_sel;
  logic [31:0] reg_wdata, reg_rdata, mem_addr, mem_rdata;
  logic mem_req, hsync_n, vsync_n, de;
  logic [7:0] red, green, blue;

  int unsigned n_chk, n_err, nce, mh, mv;
  string phase;
  logic run, done;
  logic m_en, m_rot, s_en, s_rot;
  logic [31:0] m_base, s_base, ms0, ms1, tmpw, rv;
  exp_t dl [0:LAT];
  exp_t t;

  fb_scanout #(
    .H_VIS(HV), .H_FP(HF), .H_SYNC(HSY), .H_BP(HB),
    .V_VIS(VV), .V_FP(VF), .V_SYNC(VSY), .V_BP(VB),
    .PITCH_WORDS(PW), .BASE_BITS(BB), .RD_LAT(LAT)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .hsync_n(hsync_n),
    .vsync_n(vsync_n), .de(de), .red(red), .green(green), .blue(blue)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [31:0] pix_of(logic [31:0] a);
    return {8'hC3, a[31:24] ^ a[7:0], a[15:8] ^ a[23:16], a[7:0] ^ 8'h3C};
  endfunction

  function automatic logic [31:0] exp_addr(int unsigned h, int unsigned v,
                                           logic rot, logic [31:0] base);
    int unsigned col, row;
    col = rot ? (HV - 1 - h) : h;
    row = rot ? (VV - 1 - v) : v;
    return (base & MASK) + 32'(row * PW * 4) + 32'(col * 4);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s (%s) actual=%h expected=%h", tag, phase, act, exp);
    end
  endtask

  // bench memory: two read stages advancing on ticks (R7)
  always @(posedge clk) begin
    if (pix_ce) begin
      ms0 <= mem_req ? pix_of(mem_addr) : 32'hDEAD_BEEF;
      ms1 <= ms0;
    end
  end
  assign mem_rdata = ms1;

  // expected raster model, advanced on ticks only (R11)
  always @(posedge clk) begin
    if (run && pix_ce) begin
      mh = nce % HT;
      mv = (nce / HT) % VT;
      t.de = s_en && (mh < HV) && (mv < VV);
      t.hs = !((mh >= HSB) && (mh < HSE));
      t.vs = !((mv >= VSB) && (mv < VSE));
      tmpw = pix_of(exp_addr(mh, mv, s_rot, s_base));
      t.rgb = t.de ? tmpw[23:0] : 24'h0;
      for (int i = LAT; i > 0; i--) dl[i] = dl[i-1];
      dl[0] = t;
      if ((nce % FT) == LOAD) begin  // R10 shadow copy point
        s_en = m_en; s_rot = m_rot; s_base = m_base;
      end
      nce++;
    end
  end

  // per-cycle checks away from the active edge
  always @(negedge clk) begin
    if (run && !done) begin
      mh = nce % HT;
      mv = (nce / HT) % VT;
      chk(s_en ? "R5" : "R9", {31'd0, mem_req},
          {31'd0, s_en && (mh < HV) && (mv < VV)});
      if (mem_req)
        chk(s_rot ? "R6" : "R5", mem_addr, exp_addr(mh, mv, s_rot, s_base));
      chk("R3", {31'd0, hsync_n}, {31'd0, dl[LAT].hs});
      chk("R4", {31'd0, vsync_n}, {31'd0, dl[LAT].vs});
      chk("R7", {31'd0, de}, {31'd0, dl[LAT].de});
      chk("R8", {8'd0, red, green, blue}, {8'd0, dl[LAT].rgb});
    end
  end

  task automatic wr(logic sel, logic [31:0] d);
    @(negedge clk);
    while (run && ((nce % FT) == LOAD)) @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(posedge clk);
    if (sel) begin m_en = d[0]; m_rot = d[1]; end
    else m_base = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(logic sel, logic [31:0] exp);
    @(negedge clk);
    reg_sel = sel;
    #1 chk("R1", reg_rdata, exp);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog (%s) actual=running expected=finished", phase);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    n_chk = 0; n_err = 0; nce = 0; run = 1'b0; done = 1'b0;
    m_en = 0; m_rot = 0; m_base = '0; s_en = 0; s_rot = 0; s_base = '0;
    for (int i = 0; i <= LAT; i++) dl[i] = '{de: 1'b0, hs: 1'b1, vs: 1'b1, rgb: 24'h0};
    pix_ce = 1'b1; reg_we = 1'b0; reg_sel = 1'b0; reg_wdata = '0; rst_n = 1'b0;
    phase = "reset";
    rv = $urandom(32'd7321);
    repeat (3) @(negedge clk);
    // reset state: idle outputs (R9), registers clear (R1)
    chk("R9", {31'd0, mem_req}, 32'd0);
    chk("R9", {31'd0, de}, 32'd0);
    chk("R3", {31'd0, hsync_n}, 32'd1);
    chk("R4", {31'd0, vsync_n}, 32'd1);
    chk("R8", {8'd0, red, green, blue}, 32'd0);
    chk("R1", reg_rdata, 32'd0);
    rst_n = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    run = 1'b1;

    phase = "R5 raster";
    rv = $urandom;
    wr(1'b0, rv);
    wr(1'b1, 32'h1);
    rd_chk(1'b0, rv);
    rd_chk(1'b1, 32'h1);
    repeat (3 * FT) @(negedge clk);

    phase = "R6 rotate";
    wr(1'b1, 32'h3);
    rd_chk(1'b1, 32'h3);
    repeat (2 * FT) @(negedge clk);

    phase = "R2 coarse base";
    wr(1'b0, 32'hFFFF_FFFF);
    repeat (2 * FT) @(negedge clk);
    wr(1'b0, 32'h001F_FFFC);  // only dropped bits set: fetches from zero
    rd_chk(1'b0, 32'h001F_FFFC);
    wr(1'b1, 32'h1);
    repeat (2 * FT) @(negedge clk);

    phase = "R9 disabled";
    wr(1'b1, 32'h0);
    repeat (2 * FT) @(negedge clk);
    wr(1'b1, 32'h2);
    repeat (FT) @(negedge clk);

    phase = "R10 mid-frame writes";
    wr(1'b1, 32'h1);
    for (int k = 0; k < 16; k++) begin
      wr(1'($urandom % 2), $urandom);
      repeat ($urandom % 70) @(negedge clk);
    end
    wr(1'b1, 32'h1);
    repeat (2 * FT) @(negedge clk);

    phase = "R11 random tick";
    for (int k = 0; k < 12 * FT; k++) begin
      @(negedge clk);
      pix_ce = 1'($urandom % 2);
      if (($urandom % 60) == 0) wr(1'($urandom % 2), $urandom | 32'h1);
    end
    @(negedge clk);
    pix_ce = 1'b1;
    repeat (FT) @(negedge clk);

    phase = "R1 readback";
    for (int k = 0; k < 8; k++) begin
      rv = $urandom;
      wr(1'($urandom % 2), rv);
      rd_chk(reg_sel, reg_sel ? (rv & 32'h3) : rv);
    end
    repeat (FT) @(negedge clk);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule